// File: doc/BRIEF.md
# Leaf Entry Permission Check and Fault Record Builder

This block sits after a page-table walker. It decides whether one memory access may go ahead, given the leaf entry that the walk returned. The entry's access-authority bits are decoded into a read/write/execute set. In a first-stage (guest) check, that set is then shaped by the privilege bit of the page, the problem-state bit of the requester and an authority-mask permission set. In a second-stage (host) check, the entry permissions are taken as they are. In both stages, a clear change bit removes write permission.

When the needed permission is missing, the block builds a fault record. The record holds a fault kind, cause bits, the effective address and the guest real address. It can be an instruction fault or a data fault, and either kind can come from stage one or stage two. Stage-two records carry extra address and cause information, including a marker for a table or directory pointer that could not be translated.

A request is a one-cycle pulse on `req_valid`. The results are registered: they appear one clock later with a one-cycle `resp_valid_o` pulse, and they hold until the next request.

Top module: `xlate_perm_fault`

## Requirements
- R1: Entry bit 2 grants read, entry bit 1 grants read and write, and entry bit 0 grants execute. The output permission set `perm_o` has read at bit 0, write at bit 1 and execute at bit 2.
- R2: In a stage-one check (`stage2_i`=0), a privileged page (entry bit 3 set) accessed with `problem_i`=1 gets an empty permission set.
- R3: In a stage-one check, an access with `problem_i`=0 to a page whose entry bit 3 is clear gets the decoded set ANDed with `amr_perm_i`. The other two stage-one combinations get the decoded set unchanged.
- R4: In a stage-two check (`stage2_i`=1), the decoded set is used unchanged. Entry bit 3, `problem_i` and `amr_perm_i` have no effect.
- R5: When entry bit 7 (the change bit) is clear, the write bit of `perm_o` is 0.
- R6: `acc_type_i` selects the needed permission: 0 needs read, 1 (store) needs write, 2 (fetch) needs execute, and 3 is treated as a load. `deny_o` is 1 exactly when the needed bit is absent from `perm_o`.
- R7: A denied stage-two fetch gives `fault_kind_o`=3. Its `fault_cause_o` holds the cause bits, `fault_gra_o` holds `guest_ra_i`, and `fault_ea_o` is 0.
- R8: A denied stage-two load or store gives `fault_kind_o`=4, with `fault_ea_o`=`eff_addr_i` and `fault_gra_o`=`guest_ra_i`. Every denial sets cause 0x08000000, and a denied store also sets 0x02000000.
- R9: A denied stage-two access with `tbl_ptr_i`=1 adds cause 0x00020000.
- R10: A denied stage-one fetch gives kind 1 and a denied stage-one load or store gives kind 2. Both have `fault_gra_o`=0 and never carry the table cause. Data faults record `eff_addr_i` and the store bit, while fetch faults give `fault_ea_o`=0.
- R11: Results appear the clock after `req_valid`, together with a one-cycle `resp_valid_o` pulse, and hold until the next request. A granted access gives kind 0 and zero cause and address fields.
- R12: A synchronous reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle |
| entry_i | input | ENTRY_W (8) | Leaf page entry |
| acc_type_i | input | 2 | 0 load, 1 store, 2 fetch, 3 load |
| problem_i | input | 1 | Requester in problem (user) state |
| amr_perm_i | input | 3 | Authority-mask permission set {x,w,r} |
| stage2_i | input | 1 | 1 for a second-stage (host) check |
| tbl_ptr_i | input | 1 | Translated address was a table or directory pointer |
| eff_addr_i | input | EA_W (64) | Faulting effective address |
| guest_ra_i | input | GRA_W (56) | Guest real address being translated |
| resp_valid_o | output | 1 | Result strobe, one cycle |
| perm_o | output | 3 | Allowed set {x,w,r} |
| deny_o | output | 1 | Access refused |
| fault_kind_o | output | 3 | 0 none, 1 fetch, 2 data, 3 host fetch, 4 host data |
| fault_cause_o | output | 32 | Cause bits |
| fault_ea_o | output | EA_W (64) | Recorded effective address |
| fault_gra_o | output | GRA_W (56) | Recorded guest real address |

## Verification
Several mechanisms can act on the same request. The most telling overlap is a stage-two store that is refused only because the change bit is clear, issued with the table-pointer flag set. In that one request, write removal, store denial, the store cause and the table cause all coincide, so the expected cause is 0x0A020000 with both addresses recorded. The bench drives this case and the matching stage-one case, which must show no table bit and a zero guest address. A behavioural model predicts every output on every clock, so a wrong mix of causes shows up in the cycle after the request.

// File: rtl/xpf_pkg.sv
package xpf_pkg;
  localparam int CAUSE_W = 32;

  // permission set bit positions
  localparam int PERM_R = 0;
  localparam int PERM_W = 1;
  localparam int PERM_X = 2;

  // leaf entry field positions
  localparam int ENT_X    = 0;
  localparam int ENT_RW   = 1;
  localparam int ENT_RD   = 2;
  localparam int ENT_PRIV = 3;
  localparam int ENT_CHG  = 7;

  localparam logic [CAUSE_W-1:0] CAUSE_PROT  = 32'h0800_0000;
  localparam logic [CAUSE_W-1:0] CAUSE_STORE = 32'h0200_0000;
  localparam logic [CAUSE_W-1:0] CAUSE_TABLE = 32'h0002_0000;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_t;

  typedef enum logic [2:0] {
    FK_NONE = 3'd0,
    FK_ISI  = 3'd1,
    FK_DSI  = 3'd2,
    FK_HISI = 3'd3,
    FK_HDSI = 3'd4
  } fault_kind_t;
endpackage

// File: rtl/xpf_eaa_decode.sv
module xpf_eaa_decode
  import xpf_pkg::*;
(
  input  logic [2:0] eaa_bits,
  output logic [2:0] eaa_perm
);
  // small lookup: read-write grant implies read
  always_comb begin
    eaa_perm         = '0;
    eaa_perm[PERM_R] = eaa_bits[ENT_RD] | eaa_bits[ENT_RW];
    eaa_perm[PERM_W] = eaa_bits[ENT_RW];
    eaa_perm[PERM_X] = eaa_bits[ENT_X];
  end
endmodule

// File: rtl/xpf_perm_merge.sv
module xpf_perm_merge
  import xpf_pkg::*;
(
  input  logic [2:0] eaa_perm,
  input  logic [2:0] amr_perm,
  input  logic       priv_page,
  input  logic       problem,
  input  logic       stage2,
  input  logic       change,
  input  logic [1:0] acc,
  output logic [2:0] perm,
  output logic       deny
);
  logic [2:0] base;
  logic [2:0] need;

  always_comb begin
    if (stage2)                      base = eaa_perm;
    else if (priv_page && problem)   base = '0;
    else if (!priv_page && !problem) base = eaa_perm & amr_perm;
    else                             base = eaa_perm;
    perm = base;
    if (!change) perm[PERM_W] = 1'b0;
  end

  always_comb begin
    need = '0;
    case (acc)
      ACC_STORE: need[PERM_W] = 1'b1;
      ACC_FETCH: need[PERM_X] = 1'b1;
      default:   need[PERM_R] = 1'b1;
    endcase
    deny = ((perm & need) == 3'b000);
  end
endmodule

// File: rtl/xpf_fault_build.sv
module xpf_fault_build
  import xpf_pkg::*;
#(
  parameter int EA_W  = 64,
  parameter int GRA_W = 56
) (
  input  logic               deny,
  input  logic [1:0]         acc,
  input  logic               stage2,
  input  logic               tbl_ptr,
  input  logic [EA_W-1:0]    ea,
  input  logic [GRA_W-1:0]   gra,
  output logic [2:0]         kind,
  output logic [CAUSE_W-1:0] cause,
  output logic [EA_W-1:0]    rec_ea,
  output logic [GRA_W-1:0]   rec_gra
);
  always_comb begin
    kind    = FK_NONE;
    cause   = '0;
    rec_ea  = '0;
    rec_gra = '0;
    if (deny) begin
      cause = CAUSE_PROT;
      if (stage2 && tbl_ptr) cause = cause | CAUSE_TABLE;
      if (stage2) rec_gra = gra;
      if (acc == ACC_FETCH) begin
        kind = stage2 ? FK_HISI : FK_ISI;
      end else begin
        kind   = stage2 ? FK_HDSI : FK_DSI;
        rec_ea = ea;
        if (acc == ACC_STORE) cause = cause | CAUSE_STORE;
      end
    end
  end
endmodule

// File: rtl/xlate_perm_fault.sv
module xlate_perm_fault
  import xpf_pkg::*;
#(
  parameter int ENTRY_W = 8,
  parameter int EA_W    = 64,
  parameter int GRA_W   = 56
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [ENTRY_W-1:0] entry_i,
  input  logic [1:0]         acc_type_i,
  input  logic               problem_i,
  input  logic [2:0]         amr_perm_i,
  input  logic               stage2_i,
  input  logic               tbl_ptr_i,
  input  logic [EA_W-1:0]    eff_addr_i,
  input  logic [GRA_W-1:0]   guest_ra_i,
  output logic               resp_valid_o,
  output logic [2:0]         perm_o,
  output logic               deny_o,
  output logic [2:0]         fault_kind_o,
  output logic [31:0]        fault_cause_o,
  output logic [EA_W-1:0]    fault_ea_o,
  output logic [GRA_W-1:0]   fault_gra_o
);
  localparam int MIN_ENTRY_W = ENT_CHG + 1;

  logic [2:0]         eaa_perm;
  logic [2:0]         perm_c;
  logic               deny_c;
  logic [2:0]         kind_c;
  logic [CAUSE_W-1:0] cause_c;
  logic [EA_W-1:0]    ea_c;
  logic [GRA_W-1:0]   gra_c;
  logic               unused_entry_bits;

  assign unused_entry_bits = ^entry_i[ENT_CHG-1:ENT_PRIV+1];

  generate
    if (ENTRY_W > MIN_ENTRY_W) begin : g_wide
      logic unused_entry_high;
      assign unused_entry_high = ^entry_i[ENTRY_W-1:MIN_ENTRY_W];
    end
  endgenerate

  xpf_eaa_decode u_decode (
    .eaa_bits (entry_i[2:0]),
    .eaa_perm (eaa_perm)
  );

  xpf_perm_merge u_merge (
    .eaa_perm  (eaa_perm),
    .amr_perm  (amr_perm_i),
    .priv_page (entry_i[ENT_PRIV]),
    .problem   (problem_i),
    .stage2    (stage2_i),
    .change    (entry_i[ENT_CHG]),
    .acc       (acc_type_i),
    .perm      (perm_c),
    .deny      (deny_c)
  );

  xpf_fault_build #(.EA_W(EA_W), .GRA_W(GRA_W)) u_fault (
    .deny    (deny_c),
    .acc     (acc_type_i),
    .stage2  (stage2_i),
    .tbl_ptr (tbl_ptr_i),
    .ea      (eff_addr_i),
    .gra     (guest_ra_i),
    .kind    (kind_c),
    .cause   (cause_c),
    .rec_ea  (ea_c),
    .rec_gra (gra_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid_o  <= 1'b0;
      perm_o        <= '0;
      deny_o        <= 1'b0;
      fault_kind_o  <= '0;
      fault_cause_o <= '0;
      fault_ea_o    <= '0;
      fault_gra_o   <= '0;
    end else begin
      resp_valid_o <= req_valid;
      if (req_valid) begin
        perm_o        <= perm_c;
        deny_o        <= deny_c;
        fault_kind_o  <= kind_c;
        fault_cause_o <= cause_c;
        fault_ea_o    <= ea_c;
        fault_gra_o   <= gra_c;
      end
    end
  end
endmodule

// File: rtl/xpf_checker.sv
module xpf_checker #(
  parameter int ENTRY_W = 8,
  parameter int EA_W    = 64,
  parameter int GRA_W   = 56
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic [ENTRY_W-1:0] entry_i,
  input logic               problem_i,
  input logic               stage2_i,
  input logic               tbl_ptr_i,
  input logic               resp_valid_o,
  input logic [2:0]         perm_o,
  input logic               deny_o,
  input logic [2:0]         fault_kind_o,
  input logic [31:0]        fault_cause_o,
  input logic [GRA_W-1:0]   fault_gra_o
);
  assert_priv_user_empty_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !stage2_i && problem_i && entry_i[3]) |=> (perm_o == 3'b000));

  assert_no_chg_no_write_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !entry_i[7]) |=> !perm_o[1]);

  assert_deny_has_kind_R6: assert property (@(posedge clk) disable iff (rst)
    resp_valid_o |-> (deny_o == (fault_kind_o != 3'd0)));

  assert_table_cause_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && stage2_i && tbl_ptr_i) |=> (!deny_o || fault_cause_o[17]));

  assert_stage1_no_gra_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !stage2_i) |=> ((fault_gra_o == '0) && !fault_cause_o[17]));

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(perm_o) && $stable(fault_kind_o) && $stable(fault_cause_o)
                    && !resp_valid_o));
endmodule

bind xlate_perm_fault xpf_checker #(.ENTRY_W(ENTRY_W), .EA_W(EA_W), .GRA_W(GRA_W)) u_xpf_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .entry_i       (entry_i),
  .problem_i     (problem_i),
  .stage2_i      (stage2_i),
  .tbl_ptr_i     (tbl_ptr_i),
  .resp_valid_o  (resp_valid_o),
  .perm_o        (perm_o),
  .deny_o        (deny_o),
  .fault_kind_o  (fault_kind_o),
  .fault_cause_o (fault_cause_o),
  .fault_gra_o   (fault_gra_o)
);

// File: tb/test_xlate_perm_fault.sv
module test_xlate_perm_fault;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [7:0]  entry = '0;
  logic [1:0]  acc = '0;
  logic        pr = 1'b0;
  logic [2:0]  amr = '0;
  logic        s2 = 1'b0;
  logic        tbl = 1'b0;
  logic [63:0] ea = '0;
  logic [55:0] gra = '0;

  logic        resp_valid_o;
  logic [2:0]  perm_o;
  logic        deny_o;
  logic [2:0]  fault_kind_o;
  logic [31:0] fault_cause_o;
  logic [63:0] fault_ea_o;
  logic [55:0] fault_gra_o;

  int    errors = 0;
  int    checks = 0;
  int    cycles = 0;
  bit    started = 0;
  bit    done = 0;
  string tag = "R12";
  string exp_tag = "R12";

  // reference state
  int          e_perm = 0, e_kind = 0;
  bit          e_deny = 0, e_rv = 0;
  logic [31:0] e_cause = '0;
  logic [63:0] e_ea = '0;
  logic [55:0] e_gra = '0;

  always #2 clk = ~clk;

  xlate_perm_fault i_xlate_perm_fault (
    .clk(clk), .rst(rst), .req_valid(req_valid), .entry_i(entry), .acc_type_i(acc),
    .problem_i(pr), .amr_perm_i(amr), .stage2_i(s2), .tbl_ptr_i(tbl),
    .eff_addr_i(ea), .guest_ra_i(gra), .resp_valid_o(resp_valid_o), .perm_o(perm_o),
    .deny_o(deny_o), .fault_kind_o(fault_kind_o), .fault_cause_o(fault_cause_o),
    .fault_ea_o(fault_ea_o), .fault_gra_o(fault_gra_o)
  );

  // behavioural reference model, updated on each edge
  always @(posedge clk) begin
    int p, need;
    started <= 1;
    cycles  <= cycles + 1;
    if (rst) begin
      e_perm = 0; e_kind = 0; e_deny = 0; e_rv = 0;
      e_cause = '0; e_ea = '0; e_gra = '0; exp_tag = "R12";
    end else begin
      e_rv = req_valid;
      if (req_valid) begin
        exp_tag = tag;
        p = 0;
        if (entry[2] || entry[1]) p += 1;
        if (entry[1]) p += 2;
        if (entry[0]) p += 4;
        if (!s2) begin
          if (entry[3] && pr) p = 0;
          else if (!entry[3] && !pr) p = p & int'(amr);
        end
        if (!entry[7]) p = p & 5;
        need = (acc == 2'd1) ? 2 : (acc == 2'd2) ? 4 : 1;
        e_perm = p;
        e_deny = ((p & need) == 0);
        e_kind = 0; e_cause = '0; e_ea = '0; e_gra = '0;
        if (e_deny) begin
          e_cause = 32'h0800_0000;
          if (s2 && tbl) e_cause += 32'h0002_0000;
          if (acc == 2'd2) e_kind = s2 ? 3 : 1;
          else begin
            e_kind = s2 ? 4 : 2;
            e_ea = ea;
            if (acc == 2'd1) e_cause += 32'h0200_0000;
          end
          if (s2) e_gra = gra;
        end
      end
    end
  end

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", exp_tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk("resp_valid", 64'(resp_valid_o), 64'(e_rv));
      chk("perm", 64'(perm_o), 64'(e_perm));
      chk("deny", 64'(deny_o), 64'(e_deny));
      chk("kind", 64'(fault_kind_o), 64'(e_kind));
      chk("cause", 64'(fault_cause_o), 64'(e_cause));
      chk("ea", fault_ea_o, e_ea);
      chk("gra", 64'(fault_gra_o), 64'(e_gra));
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      finish_run();
    end
  end

  task automatic req(string t, logic [7:0] e, logic [1:0] a, logic p, logic [2:0] m,
                     logic st2, logic tb, int gap);
    @(negedge clk);
    tag = t; entry = e; acc = a; pr = p; amr = m; s2 = st2; tbl = tb;
    ea = {32'hEA00_0000, 24'h0, e}; gra = {32'h00C0_FFEE, 16'h0, e};
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    entry = ~entry; amr = ~amr; ea = ~ea; gra = ~gra;  // must not disturb held record (R11)
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    req("R1",  8'h8E, 2'd0, 1'b0, 3'b000, 1'b0, 1'b0, 1);   // priv supervisor: r,w
    req("R1",  8'h89, 2'd0, 1'b0, 3'b000, 1'b0, 1'b0, 1);   // exec only, load denied
    req("R2",  8'h8F, 2'd2, 1'b1, 3'b111, 1'b0, 1'b0, 1);
    req("R3",  8'h87, 2'd1, 1'b0, 3'b001, 1'b0, 1'b0, 1);   // amr strips write
    req("R3",  8'h87, 2'd1, 1'b1, 3'b000, 1'b0, 1'b0, 1);   // user: amr ignored
    req("R4",  8'h8F, 2'd2, 1'b1, 3'b000, 1'b1, 1'b0, 1);
    req("R5",  8'h07, 2'd1, 1'b0, 3'b111, 1'b1, 1'b0, 1);
    req("R6",  8'h81, 2'd3, 1'b1, 3'b111, 1'b0, 1'b0, 0);
    req("R6",  8'h84, 2'd3, 1'b1, 3'b111, 1'b0, 1'b0, 0);
    req("R7",  8'h86, 2'd2, 1'b0, 3'b111, 1'b1, 1'b0, 1);
    req("R8",  8'h84, 2'd1, 1'b0, 3'b111, 1'b1, 1'b0, 1);
    req("R8",  8'h81, 2'd0, 1'b0, 3'b111, 1'b1, 1'b0, 1);
    req("R9",  8'h06, 2'd1, 1'b1, 3'b000, 1'b1, 1'b1, 1);   // change clear + store + table
    req("R9",  8'h06, 2'd2, 1'b1, 3'b000, 1'b1, 1'b1, 1);
    req("R10", 8'h06, 2'd1, 1'b0, 3'b111, 1'b0, 1'b1, 1);
    req("R10", 8'h06, 2'd2, 1'b0, 3'b111, 1'b0, 1'b1, 1);
    req("R11", 8'h87, 2'd0, 1'b0, 3'b111, 1'b1, 1'b1, 4);
    for (int i = 0; i < 300; i++) begin
      req("R11", 8'($urandom), 2'($urandom), 1'($urandom), 3'($urandom),
          1'($urandom), 1'($urandom), int'($urandom % 2));
    end
    @(negedge clk);
    rst = 1'b1;
    tag = "R12";
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule